// File: doc/BRIEF.md
# Cascaded Up/Down Counter with Gated Carry

This block is a wide synchronous up/down counter made from a chain of identical 4-bit digit counters. Every digit runs on one shared clock. No digit is clocked by the digit below it. The count enable of each digit is built in parallel from two things: the global enable, and the end-of-range flags of all the digits below it. As a result, a carry or borrow across many digits completes on a single clock edge.

Each digit raises its end-of-range flag at 15 when counting up and at 0 when counting down. Carries and borrows therefore use the same gating path. A digit's flag does not depend on its own enable. For that reason the global enable is ANDed into every digit's gate, not only into the lowest digit's.

An active-low load presets the whole counter from a parallel word without waiting for a clock, and it overrides counting. One output flag reports that the whole counter sits at the end of its range in the selected direction. The number of digits is the parameter `STAGES`.

Top module: `gated_cascade_counter`

Each digit steps through three named states on each clock edge:
- HOLD: not enabled, so the value is kept.
- STEP_UP: enabled with `dir_up` high, so the value goes up by 1.
- STEP_DOWN: enabled with `dir_up` low, so the value goes down by 1.

The load overrides all three. The transitions are HOLD to STEP_UP or STEP_DOWN when the digit's gate opens, and back to HOLD when it closes.

## Requirements
- R1: While `load_n` is low, `count` takes the value of `load_val` without waiting for a clock edge.
- R2: While `load_n` stays low, clock edges do not change `count` from `load_val`, whatever the enable and direction.
- R3: With `load_n` high, `cnt_en_n` low and `dir_up` high, each rising clock edge adds 1 to `count`, modulo 2^(4*STAGES).
- R4: With `load_n` high, `cnt_en_n` low and `dir_up` low, each rising clock edge subtracts 1 from `count`, modulo 2^(4*STAGES).
- R5: With `cnt_en_n` high, `count` does not change on clock edges. This holds even when the lower digits are at their end of range (for example, a held 0x0FF stays 0x0FF).
- R6: A carry through several digits completes on one edge: counting up from 0x0FF gives 0x100 after exactly one rising edge.
- R7: A borrow through several digits completes on one edge: counting down from 0x100 gives 0x0FF after exactly one rising edge.
- R8: `term_cnt` is high exactly when `count` is all ones with `dir_up` high, or all zeros with `dir_up` low. It follows `dir_up` without a clock edge and does not depend on `cnt_en_n`.
- R9: The count wraps at both ends: all ones counting up becomes all zeros, and all zeros counting down becomes all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock for every digit |
| cnt_en_n | input | 1 | Global count enable, active low |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| load_n | input | 1 | Asynchronous parallel load, active low |
| load_val | input | 4*STAGES | Value preset into the counter during a load |
| count | output | 4*STAGES | Current count |
| term_cnt | output | 1 | Whole counter at the end of its range in the selected direction |

## Verification
The load and `term_cnt` are combinational paths from the inputs. The bench checks them one nanosecond after it changes the inputs, halfway between clock edges, with no rising edge in between.

Count results take one register. The bench changes enable and direction on a falling edge and reads `count` on the next falling edge, exactly one rising edge later. A multi-digit carry or borrow that took a second edge would therefore show a stale value.

The load is released on a falling edge, so the first counting edge is the next rising edge.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        HOLD      = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/gcc_digit.sv
module gcc_digit
    import gcc_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic [W-1:0] preset,
    input  logic         gate_en,
    input  logic         dir_up,
    output logic [W-1:0] value,
    output logic         at_end
);
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] BOT_VAL = '0;

    step_e        step;
    logic [W-1:0] next_val;

    // step selection
    always_comb begin
        if (!gate_en)    step = HOLD;
        else if (dir_up) step = STEP_UP;
        else             step = STEP_DOWN;
    end

    // next value for each step
    always_comb begin
        unique case (step)
            HOLD:      next_val = value;
            STEP_UP:   next_val = value + 1'b1;
            STEP_DOWN: next_val = value - 1'b1;
            default:   next_val = value;
        endcase
    end

    // state register with asynchronous preset
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) value <= preset;
        else         value <= next_val;
    end

    // end-of-range flag, independent of this digit's own enable
    always_comb begin
        at_end = dir_up ? (value == TOP_VAL) : (value == BOT_VAL);
    end
endmodule

// File: rtl/gcc_carry_gate.sv
module gcc_carry_gate #(
    parameter int STAGES = 3
) (
    input  logic              glob_en,
    input  logic [STAGES-1:0] at_end,
    output logic [STAGES-1:0] stage_en,
    output logic              all_end
);
    // each stage gate combines the global enable with every lower flag
    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_gate
            if (k == 0) begin : g_first
                assign stage_en[k] = glob_en;
            end else begin : g_upper
                assign stage_en[k] = glob_en & (&at_end[k-1:0]);
            end
        end
    endgenerate

    assign all_end = &at_end;
endmodule

// File: rtl/gated_cascade_counter.sv
module gated_cascade_counter
    import gcc_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                        clk,
    input  logic                        cnt_en_n,
    input  logic                        dir_up,
    input  logic                        load_n,
    input  logic [DIGIT_W*STAGES-1:0]   load_val,
    output logic [DIGIT_W*STAGES-1:0]   count,
    output logic                        term_cnt
);
    localparam int CNT_W = DIGIT_W * STAGES;

    logic [STAGES-1:0] at_end;
    logic [STAGES-1:0] stage_en;

    gcc_carry_gate #(.STAGES(STAGES)) u_gate (
        .glob_en  (~cnt_en_n),
        .at_end   (at_end),
        .stage_en (stage_en),
        .all_end  (term_cnt)
    );

    genvar d;
    generate
        for (d = 0; d < STAGES; d++) begin : g_digit
            gcc_digit #(.W(DIGIT_W)) u_digit (
                .clk     (clk),
                .load_n  (load_n),
                .preset  (load_val[d*DIGIT_W +: DIGIT_W]),
                .gate_en (stage_en[d]),
                .dir_up  (dir_up),
                .value   (count[d*DIGIT_W +: DIGIT_W]),
                .at_end  (at_end[d])
            );
        end
    endgenerate
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
    parameter int STAGES = 3
) (
    input logic                  clk,
    input logic                  cnt_en_n,
    input logic                  dir_up,
    input logic                  load_n,
    input logic [4*STAGES-1:0]   load_val,
    input logic [4*STAGES-1:0]   count,
    input logic                  term_cnt
);
    localparam int CNT_W = 4 * STAGES;

    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        if (!load_n) primed <= 1'b1;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!load_n || !primed)
        cnt_en_n |=> $stable(count)); // R5

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!load_n || !primed)
        (!cnt_en_n && dir_up) |=> (count == CNT_W'($past(count) + 1'b1))); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!load_n || !primed)
        (!cnt_en_n && !dir_up) |=> (count == CNT_W'($past(count) - 1'b1))); // R4

    AST_TERM_FLAG: assert property (@(posedge clk) disable iff (!load_n || !primed)
        term_cnt == (dir_up ? (count == {CNT_W{1'b1}}) : (count == '0))); // R8

    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!primed)
        (!load_n && $stable(load_val)) |-> (count == load_val)); // R2
endmodule

bind gated_cascade_counter gcc_checker #(.STAGES(STAGES)) u_chk (
    .clk      (clk),
    .cnt_en_n (cnt_en_n),
    .dir_up   (dir_up),
    .load_n   (load_n),
    .load_val (load_val),
    .count    (count),
    .term_cnt (term_cnt)
);

// File: tb/sim_gated_cascade_counter.sv
`timescale 1ns/1ps
module sim_gated_cascade_counter;
    localparam int STAGES = 3;
    localparam int W = 4 * STAGES;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         cnt_en_n = 1'b1;
    logic         dir_up = 1'b1;
    logic         load_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         term_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gated_cascade_counter #(.STAGES(STAGES)) u0 (
        .clk(clk), .cnt_en_n(cnt_en_n), .dir_up(dir_up), .load_n(load_n),
        .load_val(load_val), .count(count), .term_cnt(term_cnt)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // preset at a falling edge, release at the next falling edge
    task automatic do_load(input logic [W-1:0] v);
        @(negedge clk);
        load_val = v;
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    // one rising edge with the given controls, checked at the following falling edge
    task automatic step(input logic en_n, input logic up);
        cnt_en_n = en_n;
        dir_up = up;
        @(negedge clk);
    endtask

    task automatic t_async_load();
        @(negedge clk);
        dir_up = 1'b1;
        load_val = 12'h5A3;
        load_n = 1'b0;
        #1;
        chk("R1 load without edge", count, 12'h5A3);
        chk("R8 flag clear after load", {11'd0, term_cnt}, 12'd0);
        @(negedge clk);
        load_n = 1'b1;
        cnt_en_n = 1'b1;
    endtask

    task automatic t_load_override();
        @(negedge clk);
        load_val = 12'h3C7;
        load_n = 1'b0;
        cnt_en_n = 1'b0;
        dir_up = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 load overrides up count", count, 12'h3C7);
        dir_up = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 load overrides down count", count, 12'h3C7);
        cnt_en_n = 1'b1;
        load_n = 1'b1;
    endtask

    task automatic t_up();
        do_load(12'h123);
        step(1'b0, 1'b1);
        chk("R3 up 1", count, 12'h124);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 up 3", count, 12'h126);
        do_load(12'h00E);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 digit carry", count, 12'h010);
        cnt_en_n = 1'b1;
    endtask

    task automatic t_down();
        do_load(12'h010);
        step(1'b0, 1'b0);
        chk("R4 digit borrow", count, 12'h00F);
        step(1'b0, 1'b0);
        chk("R4 down", count, 12'h00E);
        cnt_en_n = 1'b1;
    endtask

    task automatic t_multi_carry();
        do_load(12'h0FF);
        step(1'b0, 1'b1);
        chk("R6 carry 0FF to 100 in one edge", count, 12'h100);
        step(1'b0, 1'b0);
        chk("R7 borrow 100 to 0FF in one edge", count, 12'h0FF);
        cnt_en_n = 1'b1;
    endtask

    task automatic t_hold();
        do_load(12'h0FF);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        chk("R5 hold at 0FF upward", count, 12'h0FF);
        do_load(12'h100);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 hold at 100 downward", count, 12'h100);
    endtask

    task automatic t_wrap_and_flag();
        do_load(ONES);
        cnt_en_n = 1'b1;
        dir_up = 1'b1;
        #1;
        chk("R8 flag at all ones while disabled", {11'd0, term_cnt}, 12'd1);
        dir_up = 1'b0;
        #1;
        chk("R8 flag follows direction", {11'd0, term_cnt}, 12'd0);
        @(negedge clk);
        step(1'b0, 1'b1);
        chk("R9 wrap up", count, 12'h000);
        cnt_en_n = 1'b1;
        dir_up = 1'b0;
        #1;
        chk("R8 flag at zero counting down", {11'd0, term_cnt}, 12'd1);
        @(negedge clk);
        step(1'b0, 1'b0);
        chk("R9 wrap down", count, ONES);
        cnt_en_n = 1'b1;
    endtask

    initial begin
        t_async_load();
        t_load_override();
        t_up();
        t_down();
        t_multi_carry();
        t_hold();
        t_wrap_and_flag();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule